// File: doc/BRIEF.md
# Indexed SPI Flash Command Engine

This block is a half-duplex SPI host that runs one serial-flash command per trigger. Software fills a byte buffer with address, dummy or payload bytes and loads the command byte, a send count, a receive count and a device number through a byte-wide register port. It then writes the start bit. The engine selects the chosen device and shifts out the command byte, then the send bytes taken from the buffer. After that it clocks in the receive bytes and stores each one in the buffer, directly behind the bytes it has just sent.

All traffic uses one data line in each direction, SPI mode 0, most significant bit first. SCLK runs at a quarter of the system clock. A single buffer pointer advances by one for every byte sent from the buffer and for every byte stored into it. The pointer is kept from one command to the next and returns to zero only on a software clear. Multi-byte addresses must therefore be placed in the buffer high byte first, and dummy bytes as 0xFF.

Top module: `spi_idx_engine`

## Requirements
- R1: The register port decodes byte addresses as follows. Command byte at 0x45, send count at 0x48, receive count at 0x4B, device number at bits 1:0 of 0x1D, and the byte buffer at 0x80 to 0xC5 (70 bytes). Each of these reads back the value last written to it.
- R2: Writing a byte with bit 7 set to address 0x47 starts a command. Bit 7 of address 0x4F (bit 31 of the status word at 0x4C) reads 1 from the cycle after the start until the command finishes, and reads 0 otherwise.
- R3: A command shifts out the command byte first and then the send bytes, read from the buffer at the pointer. Each byte goes MSB first in mode 0: SCLK idles low, MOSI changes only while SCLK is low, and each SCLK period is 2 cycles high and at least 2 cycles low.
- R4: Receive bytes are clocked in only after the last send byte. They are written to the buffer at the pointer, so after a pointer clear they land at index = send count. MOSI stays high (0xFF) during the receive phase.
- R5: While a command runs, only cs_n_o[n] is low, where n is the device number. It stays low without a break from before the first SCLK edge until after the last one. When idle, all chip selects are high and SCLK is low.
- R6: While a command runs, a start write, a pointer clear and a device-number write are all ignored.
- R7: The buffer pointer advances by one per buffered byte, wraps from 69 to 0, and keeps its value across commands. Writing bit 4 of address 0x02 (bit 20 of the control word at 0x00) while idle resets it to 0.
- R8: A send or receive count above 64 is treated as 64.
- R9: With both counts zero, only the command byte is sent and the buffer is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| sclk_o | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_n_o | output | 4 | Active-low device selects |

## Verification
A pointer that is off by one shows up at the ports right away. The first send byte after the command byte comes out of the wrong buffer slot, and received bytes land in the wrong place, so the next buffer read-back exposes the fault. A sequencer that mistracks its remaining-byte counts changes the number of bytes framed by the chip select, and the scoreboard sees this as a missing or unexpected byte within one byte time (34 cycles). A shifter phase error corrupts the first byte on the wire, and the MOSI-stability and SCLK-shape checks catch it within one bit time.

// File: rtl/spi_idx_pkg.sv
package spi_idx_pkg;
  localparam int unsigned BUF_DEPTH = 70;
  localparam int unsigned MAX_DATA  = 64;
  localparam int unsigned CLK_DIV   = 4;
  localparam int unsigned NUM_CS    = 4;

  localparam logic [7:0] A_CTRL2  = 8'h02;  // bits 23:16 of control word
  localparam logic [7:0] A_CSEL   = 8'h1D;
  localparam logic [7:0] A_OPC    = 8'h45;
  localparam logic [7:0] A_TRIG   = 8'h47;
  localparam logic [7:0] A_TXC    = 8'h48;
  localparam logic [7:0] A_RXC    = 8'h4B;
  localparam logic [7:0] A_STAT3  = 8'h4F;  // bits 31:24 of status word
  localparam logic [7:0] A_BUF    = 8'h80;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} seq_state_e;
endpackage

// File: rtl/spi_idx_regfile.sv
module spi_idx_regfile
  import spi_idx_pkg::*;
#(
  parameter int unsigned DEPTH = BUF_DEPTH,
  parameter int unsigned CSW   = 2,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [7:0]     reg_wdata_i,
  output logic [7:0]     reg_rdata_o,
  input  logic           busy_i,
  input  logic [PW-1:0]  ptr_i,
  input  logic           wr_en_i,
  input  logic [7:0]     wr_data_i,
  output logic [7:0]     opcode_o,
  output logic [7:0]     tx_cnt_o,
  output logic [7:0]     rx_cnt_o,
  output logic [CSW-1:0] cs_sel_o,
  output logic           go_o,
  output logic           clr_o,
  output logic [7:0]     buf_rdata_o
);
  logic [7:0] buf_q [DEPTH];
  logic [7:0] addr_off;
  logic       in_buf;

  assign addr_off = reg_addr_i - A_BUF;
  assign in_buf   = reg_addr_i[7] && (addr_off < 8'(DEPTH));
  assign go_o     = reg_we_i && (reg_addr_i == A_TRIG) && reg_wdata_i[7] && !busy_i;
  assign clr_o    = reg_we_i && (reg_addr_i == A_CTRL2) && reg_wdata_i[4] && !busy_i;
  assign buf_rdata_o = buf_q[ptr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_o <= '0;
      tx_cnt_o <= '0;
      rx_cnt_o <= '0;
      cs_sel_o <= '0;
      for (int i = 0; i < int'(DEPTH); i++) buf_q[i] <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          A_OPC:  opcode_o <= reg_wdata_i;
          A_TXC:  tx_cnt_o <= reg_wdata_i;
          A_RXC:  rx_cnt_o <= reg_wdata_i;
          A_CSEL: if (!busy_i) cs_sel_o <= reg_wdata_i[CSW-1:0];
          default: ;
        endcase
      end
      // engine store wins over a software write in the same cycle
      if (wr_en_i) buf_q[ptr_i] <= wr_data_i;
      else if (reg_we_i && in_buf) buf_q[addr_off[PW-1:0]] <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (in_buf) reg_rdata_o = buf_q[addr_off[PW-1:0]];
    else begin
      case (reg_addr_i)
        A_OPC:   reg_rdata_o = opcode_o;
        A_TXC:   reg_rdata_o = tx_cnt_o;
        A_RXC:   reg_rdata_o = rx_cnt_o;
        A_CSEL:  reg_rdata_o = 8'(cs_sel_o);
        A_STAT3: reg_rdata_o = {busy_i, 7'b0};
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_idx_shifter.sv
module spi_idx_shifter
  import spi_idx_pkg::*;
#(
  parameter int unsigned DIV = CLK_DIV,
  localparam int unsigned HALF = DIV / 2,
  localparam int unsigned DW   = $clog2(DIV)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_data_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  logic          active_q;
  logic [DW-1:0] ph_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_sh_q;

  assign sclk_o = active_q && (ph_q >= DW'(HALF));
  assign mosi_o = tx_sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      ph_q      <= '0;
      bit_q     <= '0;
      tx_sh_q   <= 8'hFF;
      rx_byte_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (ld_i) begin
        active_q <= 1'b1;
        ph_q     <= '0;
        bit_q    <= '0;
        tx_sh_q  <= ld_data_i;
      end else if (active_q) begin
        ph_q <= (ph_q == DW'(DIV - 1)) ? '0 : ph_q + 1'b1;
        if (ph_q == DW'(HALF)) rx_byte_o <= {rx_byte_o[6:0], miso_i};  // first high cycle
        if (ph_q == DW'(DIV - 1)) begin
          tx_sh_q <= {tx_sh_q[6:0], 1'b1};
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_idx_seq.sv
module spi_idx_seq
  import spi_idx_pkg::*;
#(
  parameter int unsigned DEPTH = BUF_DEPTH,
  parameter int unsigned MAXB  = MAX_DATA,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(MAXB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          clr_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    tx_cnt_i,
  input  logic [7:0]    rx_cnt_i,
  input  logic [7:0]    buf_rdata_i,
  input  logic          done_i,
  input  logic [7:0]    rx_byte_i,
  output logic          ld_o,
  output logic [7:0]    ld_data_o,
  output logic          wr_en_o,
  output logic [7:0]    wr_data_o,
  output logic [PW-1:0] ptr_o,
  output logic          busy_o
);
  seq_state_e    st_q;
  logic [CW-1:0] tx_left_q, rx_left_q;
  logic [PW-1:0] ptr_nxt;

  function automatic logic [CW-1:0] clamp(input logic [7:0] c);
    return (c > 8'(MAXB)) ? CW'(MAXB) : CW'(c);
  endfunction

  assign ptr_nxt   = (ptr_o == PW'(DEPTH - 1)) ? '0 : ptr_o + 1'b1;
  assign wr_en_o   = done_i && (st_q == ST_RX);
  assign wr_data_o = rx_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      busy_o    <= 1'b0;
      ld_o      <= 1'b0;
      ld_data_o <= '0;
      ptr_o     <= '0;
      tx_left_q <= '0;
      rx_left_q <= '0;
    end else begin
      ld_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go_i) begin
            st_q      <= ST_TX;
            busy_o    <= 1'b1;
            ld_o      <= 1'b1;
            ld_data_o <= opcode_i;
            tx_left_q <= clamp(tx_cnt_i);
            rx_left_q <= clamp(rx_cnt_i);
          end else if (clr_i) begin
            ptr_o <= '0;
          end
        end
        ST_TX: if (done_i) begin
          if (tx_left_q != '0) begin
            ld_o      <= 1'b1;
            ld_data_o <= buf_rdata_i;
            ptr_o     <= ptr_nxt;
            tx_left_q <= tx_left_q - 1'b1;
          end else if (rx_left_q != '0) begin
            st_q      <= ST_RX;
            ld_o      <= 1'b1;
            ld_data_o <= 8'hFF;
          end else begin
            st_q   <= ST_IDLE;
            busy_o <= 1'b0;
          end
        end
        ST_RX: if (done_i) begin
          ptr_o     <= ptr_nxt;
          rx_left_q <= rx_left_q - 1'b1;
          if (rx_left_q == CW'(1)) begin
            st_q   <= ST_IDLE;
            busy_o <= 1'b0;
          end else begin
            ld_o      <= 1'b1;
            ld_data_o <= 8'hFF;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_idx_engine.sv
module spi_idx_engine
  import spi_idx_pkg::*;
#(
  parameter int unsigned DEPTH = BUF_DEPTH,
  parameter int unsigned MAXB  = MAX_DATA,
  parameter int unsigned DIV   = CLK_DIV,
  parameter int unsigned NCS   = NUM_CS,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CSW  = $clog2(NCS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_addr_i,
  input  logic [7:0]     reg_wdata_i,
  output logic [7:0]     reg_rdata_o,
  output logic           sclk_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_n_o
);
  logic           busy, go, clr, ld, done, wr_en;
  logic [7:0]     opcode, tx_cnt, rx_cnt, buf_rdata, ld_data, rx_byte, wr_data;
  logic [CSW-1:0] cs_sel;
  logic [PW-1:0]  ptr;

  spi_idx_regfile #(.DEPTH(DEPTH), .CSW(CSW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .ptr_i(ptr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .opcode_o(opcode), .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .cs_sel_o(cs_sel),
    .go_o(go), .clr_o(clr), .buf_rdata_o(buf_rdata)
  );

  spi_idx_seq #(.DEPTH(DEPTH), .MAXB(MAXB)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .clr_i(clr), .opcode_i(opcode),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .buf_rdata_i(buf_rdata),
    .done_i(done), .rx_byte_i(rx_byte), .ld_o(ld), .ld_data_o(ld_data),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .ptr_o(ptr), .busy_o(busy)
  );

  spi_idx_shifter #(.DIV(DIV)) u_shift (
    .clk_i, .rst_ni, .ld_i(ld), .ld_data_i(ld_data), .miso_i,
    .sclk_o, .mosi_o, .done_o(done), .rx_byte_o(rx_byte)
  );

  for (genvar g = 0; g < int'(NCS); g++) begin : g_cs
    assign cs_n_o[g] = !(busy && (cs_sel == CSW'(g)));
  end
endmodule

// File: rtl/spi_idx_checker.sv
module spi_idx_checker #(
  parameter int unsigned NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sclk_o,
  input logic           mosi_o,
  input logic [NCS-1:0] cs_n_o,
  input logic           busy_i
);
  p_one_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);
  p_idle_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (cs_n_o == '1 && !sclk_o));
  p_cs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cs_n_o));
  p_sclk_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !(&cs_n_o));
  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_sclk_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> sclk_o);
  p_sclk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |=> !sclk_o);
endmodule

bind spi_idx_engine spi_idx_checker #(.NCS(NCS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .cs_n_o(cs_n_o), .busy_i(busy)
);

// File: tb/spi_idx_engine_test.sv
module spi_idx_engine_test;
  localparam int DEPTH = 70;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;

  always #4 clk = ~clk;

  spi_idx_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct packed { logic [7:0] b; logic [3:0] csn; } exp_t;
  exp_t q[$];
  logic [7:0] bmodel [DEPTH];
  int mptr = 0;

  function automatic logic [7:0] pat(int n);
    return 8'(n * 29 + 17);
  endfunction

  // device model: response stream indexed by bit count since selection
  int nfall = 0, base = 0, ncap = 0;
  logic [7:0] cap = '0;
  logic sel_any;
  assign sel_any = ~&cs_n;
  always @(negedge sclk) nfall = nfall + 1;
  always @(posedge sel_any) base = nfall;
  function automatic logic pbit(int k);
    logic [7:0] v;
    v = pat(k / 8);
    return v[7 - (k % 8)];
  endfunction
  assign miso = pbit(nfall - base);

  // monitor: each completed byte on MOSI is popped against the queue
  always @(posedge sclk) begin
    exp_t e;
    cap = {cap[6:0], mosi};
    ncap = ncap + 1;
    if (ncap % 8 == 0) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R6/R3 unexpected byte act %h exp none", cap);
      end else begin
        e = q.pop_front();
        if (e.b != cap || e.csn != cs_n) begin
          fails++;
          $display("FAIL R3/R4/R5 byte act %h cs %b exp %h cs %b", cap, cs_n, e.b, e.csn);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a >= 8'h80 && a < 8'h80 + DEPTH) bmodel[a - 8'h80] = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(8'h4F, s); n++; end while (s[7] && n < 5000);
    chk("R2 busy clears", 32'(s), 32'h0);
    repeat (4) @(negedge clk);
    chk("R3 all bytes sent", q.size(), 0);
    chk("R5 idle selects", 32'(cs_n), 32'hF);
  endtask

  task automatic issue(input logic [1:0] cs, input logic [7:0] op, input int txn, input int rxn);
    exp_t e;
    int te = (txn > 64) ? 64 : txn;
    int re = (rxn > 64) ? 64 : rxn;
    e.csn = ~(4'b1 << cs);
    e.b = op; q.push_back(e);
    for (int k = 0; k < te; k++) begin
      e.b = bmodel[mptr]; q.push_back(e);
      mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
    end
    for (int j = 0; j < re; j++) begin
      e.b = 8'hFF; q.push_back(e);
      bmodel[mptr] = pat(1 + te + j);
      mptr = (mptr == DEPTH - 1) ? 0 : mptr + 1;
    end
    wr(8'h45, op); wr(8'h48, 8'(txn)); wr(8'h4B, 8'(rxn)); wr(8'h1D, 8'(cs));
    wr(8'h47, 8'h80);
  endtask

  task automatic check_buf(input string req);
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'(8'h80 + i), d);
      chk(req, 32'(d), 32'(bmodel[i]));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) bmodel[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    rd(8'h4F, d); chk("R2 reset status", 32'(d), 0);
    rd(8'h45, d); chk("R1 reset opcode", 32'(d), 0);
    chk("R5 reset selects", 32'(cs_n), 32'hF);
    chk("R5 reset sclk", 32'(sclk), 0);

    // register readback
    wr(8'h80, 8'h12); wr(8'h81, 8'h34); wr(8'h82, 8'h56); wr(8'hC5, 8'hA5);
    rd(8'hC5, d); chk("R1 buffer top", 32'(d), 32'hA5);
    wr(8'h48, 8'h21); rd(8'h48, d); chk("R1 send count", 32'(d), 32'h21);
    wr(8'h4B, 8'h13); rd(8'h4B, d); chk("R1 receive count", 32'(d), 32'h13);

    // R3 R4: 3-byte address, 4 receive bytes, device 2
    issue(2'd2, 8'h9F, 3, 4);
    rd(8'h4F, d); chk("R2 busy set", 32'(d), 32'h80);
    // R6: start, clear and device writes while busy
    wr(8'h47, 8'h80); wr(8'h02, 8'h10); wr(8'h1D, 8'h00);
    wait_idle();
    rd(8'h1D, d); chk("R6 device kept", 32'(d), 2);
    check_buf("R4 receive placement");

    // R7: no clear, pointer continues at 7
    wr(8'h87, 8'h7E);
    issue(2'd1, 8'h05, 1, 1);
    wait_idle();
    check_buf("R7 pointer kept");

    // R9: clear, command byte only
    wr(8'h02, 8'h10); mptr = 0;
    issue(2'd0, 8'h06, 0, 0);
    wait_idle();
    check_buf("R9 buffer untouched");

    // R8: receive count clamp
    wr(8'hC0, 8'hEE);
    issue(2'd3, 8'h0B, 0, 100);
    wait_idle();
    check_buf("R8 receive clamp");

    // R7: wrap from 69 to 0
    issue(2'd3, 8'h03, 0, 8);
    wait_idle();
    check_buf("R7 wrap");

    // R8: send count clamp
    issue(2'd1, 8'h02, 200, 0);
    wait_idle();
    check_buf("R8 send clamp");

    finished = 1;
    summary();
    $finish;
  end
endmodule